// File: doc/BRIEF.md
# Mixed-Sign Fractional Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit fixed-point signal processor. It multiplies a signed two's-complement operand by an unsigned operand and treats the product as a fraction, meaning the integer product is shifted left by one bit. The product is sign-extended to the 36-bit accumulator width and added to the current destination value. The accumulator is made of a 4-bit extension, a 16-bit high word and a 16-bit low word.

The destination is either a full 36-bit accumulator or a 16-bit register. A 16-bit register takes part in the addition as the high word of a fraction, and only bits 31..16 of the sum are written back. Nothing corrects a sign that is lost in that truncation. The saturation mode never changes the result. The block returns the new destination value together with condition flags. The flags are registered in the same cycle as the result, and a sticky limit flag holds until software clears it. The block does not decode instructions and has no register file.

Top module: `mixsign_mac`

## Requirements
- R1: On a cycle with `valid_i` high, the product is (signed `op_s_i`) × (unsigned `op_u_i`) × 2. It is sign-extended to 36 bits and added to the addend. When `dst_short_i` is 0, the addend is `dst_i` and `res_o` receives the whole 36-bit sum. Example: addend 0x0_0000_0020 with operands 0xFFF4 and 0x0002 gives 0xF_FFFF_FFF0.
- R2: The doubled product keeps its full 33-bit signed range and is not wrapped at 32 bits. For example, 0x7FFF × 0xFFFF adds +0xFFFD_0002, and 0x8000 × 0xFFFF adds −0xFFFF_0000.
- R3: When `dst_short_i` is 1, the addend is {4 copies of `dst_i[15]`, `dst_i[15:0]`, 16'h0}. `res_o` is then {20'h0, sum[31:16]}. Bits 35..16 of `dst_i` are ignored, and a sign lost in the truncation is not corrected.
- R4: `sat_mode_i` has no effect on the result or on any flag.
- R5: The flags are computed from the 36-bit sum in both destination modes. `flag_n_o` = sum[35]. `flag_z_o` is 1 when all 36 bits of the sum are 0.
- R6: `flag_v_o` is 1 when the addend and the extended product have the same bit 35 and the bit 35 of the sum differs from it.
- R7: `flag_e_o` is 1 when sum bits 35..31 are not all equal. `flag_u_o` is 1 when sum bit 31 equals sum bit 30.
- R8: `flag_l_o` is set by a valid operation whose V is 1, and it then stays set. A cycle with `clr_limit_i` high clears it, unless the same cycle also sets it, in which case it stays set.
- R9: The result and the flags appear one clock after `valid_i`. They hold while `valid_i` is low. The asynchronous reset `rst_ni` clears them all to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Perform one operation this cycle |
| op_s_i | input | 16 | Signed operand |
| op_u_i | input | 16 | Unsigned operand |
| dst_i | input | 36 | Current destination value |
| dst_short_i | input | 1 | 1: 16-bit register destination, 0: accumulator |
| sat_mode_i | input | 1 | Saturation mode (ignored) |
| clr_limit_i | input | 1 | Clear the sticky limit flag |
| res_o | output | 36 | New destination value |
| flag_l_o | output | 1 | Sticky limit flag |
| flag_e_o | output | 1 | Extension in use |
| flag_u_o | output | 1 | Unnormalized |
| flag_n_o | output | 1 | Negative |
| flag_z_o | output | 1 | Zero |
| flag_v_o | output | 1 | Overflow |

## Verification
A cycle can carry both an overflowing operation, which sets the sticky limit flag, and a request to clear that flag. The bench provokes this by driving an overflowing vector with `clr_limit_i` high. It expects the flag to stay set, because setting has priority over clearing. The bench then repeats the clear alongside an operation that does not overflow, and expects the flag to drop. Both outcomes are read at the port one clock later, in the same cycle as the new result.

// File: rtl/mixmac_pkg.sv
package mixmac_pkg;
  typedef struct packed {
    logic ext;
    logic unnorm;
    logic neg;
    logic zero;
    logic ovf;
  } cc_t;
endpackage

// File: rtl/mixmac_mult.sv
module mixmac_mult #(
  parameter int unsigned OP_W = 16,
  localparam int unsigned PW  = 2 * OP_W + 1
) (
  input  logic [OP_W-1:0] op_s_i,
  input  logic [OP_W-1:0] op_u_i,
  output logic [PW-1:0]   prod_o
);
  logic signed [PW-1:0] s_ext, u_ext, raw;

  always_comb begin
    s_ext  = {{(OP_W+1){op_s_i[OP_W-1]}}, op_s_i};
    u_ext  = {{(OP_W+1){1'b0}}, op_u_i};
    raw    = s_ext * u_ext;
    prod_o = raw <<< 1;  // fractional alignment
  end

  always_comb begin
    if (op_s_i == '0 || op_u_i == '0)
      assert_zero_operand_R1: assert (prod_o == '0) else $error("zero operand gave nonzero product");
  end
endmodule

// File: rtl/mixmac_add.sv
module mixmac_add #(
  parameter int unsigned ACC_W = 36,
  parameter int unsigned PW    = 33
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [PW-1:0]    prod_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             ovf_o
);
  logic [ACC_W-1:0] p_ext;

  always_comb begin
    p_ext = {{(ACC_W-PW){prod_i[PW-1]}}, prod_i};
    sum_o = acc_i + p_ext;
    ovf_o = (acc_i[ACC_W-1] == p_ext[ACC_W-1]) && (sum_o[ACC_W-1] != acc_i[ACC_W-1]);
  end

  always_comb begin
    if (prod_i == '0)
      assert_no_ovf_on_zero_R6: assert (!ovf_o && sum_o == acc_i) else $error("zero product changed sum");
  end
endmodule

// File: rtl/mixmac_flags.sv
module mixmac_flags
  import mixmac_pkg::*;
#(
  parameter int unsigned ACC_W  = 36,
  parameter int unsigned FRAC_W = 32
) (
  input  logic [ACC_W-1:0] sum_i,
  input  logic             ovf_i,
  output cc_t              cc_o
);
  localparam int unsigned XW = ACC_W - FRAC_W + 1;
  logic [XW-1:0] top_bits;

  always_comb begin
    top_bits    = sum_i[ACC_W-1:FRAC_W-1];
    cc_o.ext    = !((&top_bits) || !(|top_bits));
    cc_o.unnorm = sum_i[FRAC_W-1] == sum_i[FRAC_W-2];
    cc_o.neg    = sum_i[ACC_W-1];
    cc_o.zero   = sum_i == '0;
    cc_o.ovf    = ovf_i;
  end

  always_comb begin
    if (!cc_o.ext)
      assert_ext_sign_R7: assert (sum_i[ACC_W-1] == sum_i[FRAC_W-1]) else $error("ext clear but sign differs");
    if (cc_o.zero)
      assert_zero_excl_R5: assert (!cc_o.neg && !cc_o.ext && cc_o.unnorm) else $error("zero flag inconsistent");
  end
endmodule

// File: rtl/mixsign_mac.sv
module mixsign_mac
  import mixmac_pkg::*;
#(
  parameter  int unsigned OP_W  = 16,
  parameter  int unsigned EXT_W = 4,
  localparam int unsigned ACC_W = EXT_W + 2 * OP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_s_i,
  input  logic [OP_W-1:0]  op_u_i,
  input  logic [ACC_W-1:0] dst_i,
  input  logic             dst_short_i,
  input  logic             sat_mode_i,
  input  logic             clr_limit_i,
  output logic [ACC_W-1:0] res_o,
  output logic             flag_l_o,
  output logic             flag_e_o,
  output logic             flag_u_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o
);
  localparam int unsigned FRAC_W = 2 * OP_W;
  localparam int unsigned PW     = FRAC_W + 1;

  logic [PW-1:0]    prod;
  logic [ACC_W-1:0] addend, sum, next_res;
  logic             ovf;
  cc_t              cc_d, cc_q;
  logic [ACC_W-1:0] res_q;
  logic             lim_q;
  logic             sat_unused;

  assign sat_unused = sat_mode_i;  // result never limited

  always_comb begin
    addend = dst_short_i ? {{EXT_W{dst_i[OP_W-1]}}, dst_i[OP_W-1:0], {OP_W{1'b0}}} : dst_i;
  end

  mixmac_mult #(.OP_W(OP_W)) i_mult (
    .op_s_i (op_s_i),
    .op_u_i (op_u_i),
    .prod_o (prod)
  );

  mixmac_add #(.ACC_W(ACC_W), .PW(PW)) i_add (
    .acc_i  (addend),
    .prod_i (prod),
    .sum_o  (sum),
    .ovf_o  (ovf)
  );

  mixmac_flags #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) i_flags (
    .sum_i (sum),
    .ovf_i (ovf),
    .cc_o  (cc_d)
  );

  always_comb begin
    next_res = dst_short_i ? {{(ACC_W-OP_W){1'b0}}, sum[FRAC_W-1:OP_W]} : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      cc_q  <= '0;
      lim_q <= 1'b0;
    end else begin
      if (valid_i) begin
        res_q <= next_res;
        cc_q  <= cc_d;
      end
      // set beats clear
      if (valid_i && ovf)  lim_q <= 1'b1;
      else if (clr_limit_i) lim_q <= 1'b0;
    end
  end

  assign res_o    = res_q;
  assign flag_l_o = lim_q;
  assign flag_e_o = cc_q.ext;
  assign flag_u_o = cc_q.unnorm;
  assign flag_n_o = cc_q.neg;
  assign flag_z_o = cc_q.zero;
  assign flag_v_o = cc_q.ovf;

  assert_limit_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q && !clr_limit_i |=> lim_q) else $error("limit flag dropped");
  assert_ovf_sets_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ovf |=> lim_q && flag_v_o) else $error("overflow not latched");
  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(cc_q)) else $error("outputs moved while idle");
  assert_short_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dst_short_i |=> res_o[ACC_W-1:OP_W] == '0) else $error("short result upper bits set");
endmodule

// File: tb/test_mixsign_mac.sv
`timescale 1ns/1ps
module test_mixsign_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] op_s = '0, op_u = '0;
  logic [35:0] dst = '0;
  logic        shrt = 1'b0, sat = 1'b0, clr = 1'b0;
  logic [35:0] res;
  logic        fl, fe, fu, fn, fz, fv;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mixsign_mac i_mixsign_mac (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_s_i(op_s), .op_u_i(op_u),
    .dst_i(dst), .dst_short_i(shrt), .sat_mode_i(sat), .clr_limit_i(clr),
    .res_o(res), .flag_l_o(fl), .flag_e_o(fe), .flag_u_o(fu), .flag_n_o(fn),
    .flag_z_o(fz), .flag_v_o(fv)
  );

  typedef struct packed {
    logic [15:0] s;
    logic [15:0] u;
    logic [35:0] d;
    logic        sh;
    logic        st;
    logic [35:0] exp_res;
    logic [4:0]  exp_cc;  // {E,U,N,Z,V}
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'hFFF4, 16'h0002, 36'h0_0000_0020, 1'b0, 1'b0, 36'hF_FFFF_FFF0, 5'b01100}, // R1 example
    '{16'h0001, 16'h0001, 36'h0_0000_0000, 1'b0, 1'b0, 36'h0_0000_0002, 5'b01000}, // R1
    '{16'h0000, 16'hFFFF, 36'h0_0000_0000, 1'b0, 1'b0, 36'h0_0000_0000, 5'b01010}, // R5 zero
    '{16'h7FFF, 16'hFFFF, 36'h0_0000_0000, 1'b0, 1'b0, 36'h0_FFFD_0002, 5'b11000}, // R2 R7
    '{16'h8000, 16'hFFFF, 36'h0_0000_0000, 1'b0, 1'b0, 36'hF_0001_0000, 5'b11100}, // R2 R5
    '{16'h4000, 16'h0002, 36'h7_FFFF_FFFF, 1'b0, 1'b0, 36'h8_0000_FFFF, 5'b11101}, // R6 positive overflow
    '{16'hFFFF, 16'h0001, 36'h8_0000_0000, 1'b0, 1'b0, 36'h7_FFFF_FFFE, 5'b11001}, // R6 negative overflow
    '{16'h4000, 16'h8000, 36'hF_FFFF_1000, 1'b1, 1'b0, 36'h0_0000_5000, 5'b00000}, // R3 R7 U clear
    '{16'h7FFF, 16'hFFFF, 36'h0_0000_7000, 1'b1, 1'b0, 36'h0_0000_6FFD, 5'b10000}, // R3 sign lost
    '{16'h4000, 16'h0002, 36'h7_FFFF_FFFF, 1'b0, 1'b1, 36'h8_0000_FFFF, 5'b11101}, // R4 sat ignored
    '{16'h0000, 16'h1234, 36'h0_0000_8000, 1'b1, 1'b0, 36'h0_0000_8000, 5'b00100}  // R3 negative word
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [15:0] s, input logic [15:0] u, input logic [35:0] d,
                       input logic sh, input logic st, input logic cl);
    @(negedge clk);
    op_s = s; op_u = u; dst = d; shrt = sh; sat = st; clr = cl; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  function automatic logic [4:0] cc_now();
    return {fe, fu, fn, fz, fv};
  endfunction

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #23;
    chk("R9 reset res", 64'(res), 64'h0);
    chk("R9 reset flags", 64'({fl, cc_now()}), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].s, VECS[i].u, VECS[i].d, VECS[i].sh, VECS[i].st, 1'b0);
      chk($sformatf("table vec %0d res R1 R2 R3 R4", i), 64'(res), 64'(VECS[i].exp_res));
      chk($sformatf("table vec %0d flags R5 R6 R7", i), 64'(cc_now()), 64'(VECS[i].exp_cc));
    end

    // R8: last vector had no overflow, L still held
    chk("R8 sticky after clean op", 64'(fl), 64'h1);

    // R8 clear without an operation; R9 result holds
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R8 clear alone", 64'(fl), 64'h0);
    chk("R9 hold during clear", 64'(res), 64'h8000);

    // R9 idle inputs change nothing
    @(negedge clk); op_s = 16'h7FFF; op_u = 16'hFFFF; dst = 36'h7_FFFF_FFFF; shrt = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 idle hold res", 64'(res), 64'h8000);
    chk("R9 idle hold flags", 64'(cc_now()), 64'(5'b00100));

    // R9 latency: no change before the edge, new value after it
    @(negedge clk);
    op_s = 16'h0001; op_u = 16'h0003; dst = 36'h0_0000_0010; shrt = 1'b0; sat = 1'b0; valid = 1'b1;
    @(posedge clk); #1;
    chk("R9 value one edge later", 64'(res), 64'h16);
    @(negedge clk); valid = 1'b0;

    // R8 set and clear in same cycle: set wins
    do_op(16'h4000, 16'h0002, 36'h7_FFFF_FFFF, 1'b0, 1'b0, 1'b1);
    chk("R8 set beats clear", 64'(fl), 64'h1);
    chk("R6 overflow flag", 64'(fv), 64'h1);

    // R8 clear with a clean op
    do_op(16'h0001, 16'h0001, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1);
    chk("R8 clear with clean op", 64'(fl), 64'h0);
    chk("R1 clean op res", 64'(res), 64'h2);

    // R4 sat high on overflow case leaves no limiting
    do_op(16'hFFFF, 16'h0001, 36'h8_0000_0000, 1'b0, 1'b1, 1'b0);
    chk("R4 no saturation", 64'(res), 64'h7_FFFF_FFFE);

    // R9 asynchronous reset
    @(negedge clk); #2 rst_n = 1'b0; #1;
    chk("R9 async reset res", 64'(res), 64'h0);
    chk("R9 async reset flags", 64'({fl, cc_now()}), 64'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule